// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate or DDR-style DRAM device from reset to a usable state. When reset is released, it holds the command bus at NOP for a power-up interval while the clock keeps running. It then issues the start-up commands in a fixed order:

- a precharge of every bank;
- a load of the mode register;
- a load of the extended mode register;
- a parameter-set number of auto-refresh commands.

A wait of NOP cycles follows every command. The length of each wait comes from its own timing parameter: a precharge wait, a mode-load wait and a refresh wait.

When the last refresh wait ends, the block arms its periodic refresh interval counter and raises the done flag in the same cycle. Outputs are the active-low command strobes, the address and bank lines, the done flag and a periodic refresh request. The memory controller holds back normal accesses until the done flag is high. From then on it issues a refresh each time the request pulses. Reset may be applied at any moment and restarts the whole sequence.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset is released, the command bus shows NOP for exactly CLK_MHZ*P cycles, where P is PWRUP_US clamped to the range 100 to 200.
- R2: The command bus {cs_n,ras_n,cas_n,we_n} only ever carries NOP=0111, precharge=0010, auto-refresh=0001 or mode load=0000.
- R3: The first command is a precharge held for one cycle, with address bit 10 high, all other address bits 0 and bank 00.
- R4: The precharge is followed by exactly T_RP NOP cycles and then a mode load on bank 00. The address carries burst-length code in bits [2:0], burst type in bit 3, CAS latency in bits [6:4], and 0 in all higher bits.
- R5: The mode load is followed by exactly T_MRD NOP cycles and then a mode load on bank 01. The address carries DLL-off in bit 0, reduced drive in bit 1, the self-refresh option in bits [4:2], and 0 in all higher bits.
- R6: The extended load is followed by exactly T_MRD NOP cycles. Then come max(N_REF,2) auto-refresh commands, each one cycle long with address and bank 0, and each followed by exactly T_RFC NOP cycles.
- R7: init_done rises in the cycle after the last refresh wait, stays high until reset, and the command bus stays at NOP while it is high.
- R8: refresh_req is a one-cycle pulse. It first occurs T_REFI cycles after init_done rises and then repeats every T_REFI cycles. It is never high while init_done is low.
- R9: Reset applied in any state gives NOP with zero address and bank, init_done low and refresh_req low after the next clock edge. After release, the full sequence restarts from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, running throughout the power-up interval |
| rst | input | 1 | Synchronous active-high reset |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| dram_addr | output | ADDR_W | Address lines; carry the precharge-all bit and mode payloads |
| dram_ba | output | BA_W | Bank lines; select the mode register (00) or the extended mode register (01) |
| init_done | output | 1 | High once start-up is complete |
| refresh_req | output | 1 | One-cycle periodic refresh request after start-up |

## Verification
Every fault in this block shows up as a shifted or malformed command on the bus. A corrupted wait counter or refresh tally moves every later command by at least one cycle. A wrong state decode emits a command with the wrong encoding or payload in the very cycle the state is entered. For this reason the bench compares the full output bundle every cycle against an arithmetic timeline, for two differently parameterised instances. It applies reset during the power-up wait, in the middle of the refresh phase and after completion. Any deviation is caught in the first cycle it appears, with no need to wait for a later symptom.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_PWR_WAIT = 4'd0,
        ST_PRECHG   = 4'd1,
        ST_WAIT_RP  = 4'd2,
        ST_LOAD_MR  = 4'd3,
        ST_WAIT_MR  = 4'd4,
        ST_LOAD_EMR = 4'd5,
        ST_WAIT_EMR = 4'd6,
        ST_AUTOREF  = 4'd7,
        ST_WAIT_RFC = 4'd8,
        ST_READY    = 4'd9
    } init_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_PRE   = 4'b0010;
    localparam logic [3:0] CMD_AREF  = 4'b0001;
    localparam logic [3:0] CMD_MLOAD = 4'b0000;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/init_cmd_map.sv
module init_cmd_map
    import sdram_init_pkg::*;
#(
    parameter int          ADDR_W        = 13,
    parameter int          BA_W          = 2,
    parameter logic [2:0]  BURST_LEN     = 3'b010,
    parameter bit          BURST_ILV     = 1'b0,
    parameter logic [2:0]  CAS_LAT       = 3'd3,
    parameter bit          DLL_OFF       = 1'b0,
    parameter bit          DRIVE_REDUCED = 1'b0,
    parameter logic [2:0]  SELF_REF_OPT  = 3'b000
) (
    input  init_state_e         st,
    output logic [3:0]          cmd,
    output logic [ADDR_W-1:0]   addr,
    output logic [BA_W-1:0]     ba
);
    localparam logic [6:0] MR_WORD  = {CAS_LAT, BURST_ILV, BURST_LEN};
    localparam logic [4:0] EMR_WORD = {SELF_REF_OPT, DRIVE_REDUCED, DLL_OFF};
    localparam int         AP_BIT   = 10;

    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        unique case (st)
            ST_PRECHG: begin
                cmd          = CMD_PRE;
                addr[AP_BIT] = 1'b1;
            end
            ST_LOAD_MR: begin
                cmd        = CMD_MLOAD;
                addr[6:0]  = MR_WORD;
            end
            ST_LOAD_EMR: begin
                cmd        = CMD_MLOAD;
                addr[4:0]  = EMR_WORD;
                ba         = BA_W'(1);
            end
            ST_AUTOREF: cmd = CMD_AREF;
            default:    cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/init_refi_timer.sv
module init_refi_timer #(
    parameter int T_REFI = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic req
);
    localparam int RI_W = (T_REFI > 2) ? $clog2(T_REFI) : 1;
    localparam logic [RI_W-1:0] RELOAD = RI_W'(T_REFI - 1);

    typedef struct packed {
        logic            active;
        logic [RI_W-1:0] cnt;
        logic            req;
    } refi_t;

    refi_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.req = 1'b0;
        if (arm) begin
            r_d.active = 1'b1;
            r_d.cnt    = RELOAD;
        end else if (r_q.active) begin
            if (r_q.cnt == '0) begin
                r_d.req = 1'b1;
                r_d.cnt = RELOAD;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign req = r_q.req;

    // R8: a request needs the counter to have been armed first
    p_req_after_arm_r8: assert property (@(posedge clk) disable iff (rst)
        req |-> r_q.active);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int          CLK_MHZ       = 50,
    parameter int          PWRUP_US      = 100,
    parameter int          T_RP          = 3,
    parameter int          T_MRD         = 2,
    parameter int          T_RFC         = 7,
    parameter int          N_REF         = 2,
    parameter int          T_REFI        = 390,
    parameter int          ADDR_W        = 13,
    parameter int          BA_W          = 2,
    parameter logic [2:0]  BURST_LEN     = 3'b010,
    parameter bit          BURST_ILV     = 1'b0,
    parameter logic [2:0]  CAS_LAT       = 3'd3,
    parameter bit          DLL_OFF       = 1'b0,
    parameter bit          DRIVE_REDUCED = 1'b0,
    parameter logic [2:0]  SELF_REF_OPT  = 3'b000
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [ADDR_W-1:0] dram_addr,
    output logic [BA_W-1:0]   dram_ba,
    output logic              init_done,
    output logic              refresh_req
);
    localparam int US_EFF = (PWRUP_US < 100) ? 100 : ((PWRUP_US > 200) ? 200 : PWRUP_US);
    localparam int STABLE = CLK_MHZ * US_EFF;
    localparam int N_EFF  = (N_REF < 2) ? 2 : N_REF;
    localparam int TMR_W  = $clog2(max_of4(STABLE, T_RP, T_MRD, T_RFC) + 1);
    localparam int RC_W   = $clog2(N_EFF + 1);

    localparam logic [TMR_W-1:0] LD_STABLE = TMR_W'(STABLE);
    localparam logic [TMR_W-1:0] LD_RP     = TMR_W'(T_RP - 1);
    localparam logic [TMR_W-1:0] LD_MRD    = TMR_W'(T_MRD - 1);
    localparam logic [TMR_W-1:0] LD_RFC    = TMR_W'(T_RFC - 1);
    localparam logic [RC_W-1:0]  REF_LAST  = RC_W'(N_EFF);

    typedef struct packed {
        init_state_e      st;
        logic [TMR_W-1:0] tmr;
        logic [RC_W-1:0]  refs;
    } seq_t;

    seq_t s_q, s_d;
    logic tmr_zero;
    logic arm_refi;

    assign tmr_zero = (s_q.tmr == '0);

    always_comb begin
        s_d = s_q;
        if (!tmr_zero) s_d.tmr = s_q.tmr - 1'b1;
        unique case (s_q.st)
            ST_PWR_WAIT: if (tmr_zero) s_d.st = ST_PRECHG;
            ST_PRECHG: begin
                s_d.st  = ST_WAIT_RP;
                s_d.tmr = LD_RP;
            end
            ST_WAIT_RP:  if (tmr_zero) s_d.st = ST_LOAD_MR;
            ST_LOAD_MR: begin
                s_d.st  = ST_WAIT_MR;
                s_d.tmr = LD_MRD;
            end
            ST_WAIT_MR:  if (tmr_zero) s_d.st = ST_LOAD_EMR;
            ST_LOAD_EMR: begin
                s_d.st  = ST_WAIT_EMR;
                s_d.tmr = LD_MRD;
            end
            ST_WAIT_EMR: if (tmr_zero) s_d.st = ST_AUTOREF;
            ST_AUTOREF: begin
                s_d.st   = ST_WAIT_RFC;
                s_d.tmr  = LD_RFC;
                s_d.refs = s_q.refs + 1'b1;
            end
            ST_WAIT_RFC: begin
                if (tmr_zero) begin
                    s_d.st = (s_q.refs == REF_LAST) ? ST_READY : ST_AUTOREF;
                end
            end
            ST_READY:    s_d.st = ST_READY;
            default:     s_d.st = ST_PWR_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.st   <= ST_PWR_WAIT;
            s_q.tmr  <= LD_STABLE;
            s_q.refs <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign arm_refi = (s_d.st == ST_READY) && (s_q.st != ST_READY);

    logic [3:0] cmd_w;

    init_cmd_map #(
        .ADDR_W        (ADDR_W),
        .BA_W          (BA_W),
        .BURST_LEN     (BURST_LEN),
        .BURST_ILV     (BURST_ILV),
        .CAS_LAT       (CAS_LAT),
        .DLL_OFF       (DLL_OFF),
        .DRIVE_REDUCED (DRIVE_REDUCED),
        .SELF_REF_OPT  (SELF_REF_OPT)
    ) u_cmd_map (
        .st   (s_q.st),
        .cmd  (cmd_w),
        .addr (dram_addr),
        .ba   (dram_ba)
    );

    init_refi_timer #(
        .T_REFI (T_REFI)
    ) u_refi (
        .clk (clk),
        .rst (rst),
        .arm (arm_refi),
        .req (refresh_req)
    );

    assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_w;
    assign init_done = (s_q.st == ST_READY);

    // R2: only the four legal encodings appear
    p_cmd_legal_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_w == CMD_NOP) || (cmd_w == CMD_PRE) || (cmd_w == CMD_AREF) || (cmd_w == CMD_MLOAD));

    // R3: precharge always targets all banks
    p_pre_all_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_w == CMD_PRE) |-> dram_addr[10]);

    // R6: every command is followed by at least one NOP
    p_cmd_then_nop_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_w != CMD_NOP) |=> (cmd_w == CMD_NOP));

    // R6: refresh tally never exceeds the configured count
    p_refs_bound_r6: assert property (@(posedge clk) disable iff (rst)
        s_q.refs <= REF_LAST);

    // R7: done is sticky and the bus is quiet afterwards
    p_done_holds_r7: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cmd_w == CMD_NOP));

    // R8: requests are single pulses and only after done
    p_req_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
        refresh_req |-> init_done);
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        refresh_req |=> !refresh_req);

endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [12:0] addr;
        logic [1:0]  ba;
        logic        done;
        logic        req;
    } obs_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks   = 0;
    int   failures = 0;
    int   e        = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    // Instance A: defaults except refresh interval
    localparam int A_STAB = 50 * 100, A_RP = 3, A_MRD = 2, A_RFC = 7, A_NREF = 2, A_REFI = 20;
    localparam int A_MW = 2 | (0 << 3) | (3 << 4);
    localparam int A_EW = 0;
    // Instance B: clamped power-up (250 -> 200), tight waits, more refreshes
    localparam int B_STAB = 10 * 200, B_RP = 1, B_MRD = 1, B_RFC = 1, B_NREF = 5, B_REFI = 3;
    localparam int B_MW = 3 | (1 << 3) | (2 << 4);
    localparam int B_EW = 0 | (1 << 1) | (5 << 2);

    logic a_cs, a_ras, a_cas, a_we, a_done, a_req;
    logic [12:0] a_addr;
    logic [1:0]  a_ba;
    logic b_cs, b_ras, b_cas, b_we, b_done, b_req;
    logic [12:0] b_addr;
    logic [1:0]  b_ba;

    sdram_init_seq #(.T_REFI(A_REFI)) u_sdram_init_seq (
        .clk(clk), .rst(rst),
        .cmd_cs_n(a_cs), .cmd_ras_n(a_ras), .cmd_cas_n(a_cas), .cmd_we_n(a_we),
        .dram_addr(a_addr), .dram_ba(a_ba), .init_done(a_done), .refresh_req(a_req));

    sdram_init_seq #(
        .CLK_MHZ(10), .PWRUP_US(250), .T_RP(B_RP), .T_MRD(B_MRD), .T_RFC(B_RFC),
        .N_REF(B_NREF), .T_REFI(B_REFI), .BURST_LEN(3'b011), .BURST_ILV(1'b1),
        .CAS_LAT(3'd2), .DLL_OFF(1'b0), .DRIVE_REDUCED(1'b1), .SELF_REF_OPT(3'b101)
    ) u_sdram_init_seq_alt (
        .clk(clk), .rst(rst),
        .cmd_cs_n(b_cs), .cmd_ras_n(b_ras), .cmd_cas_n(b_cas), .cmd_we_n(b_we),
        .dram_addr(b_addr), .dram_ba(b_ba), .init_done(b_done), .refresh_req(b_req));

    function automatic obs_t mk(input logic [3:0] c, input int a, input int b,
                                input logic d, input logic r);
        obs_t o;
        o.cmd = c; o.addr = 13'(a); o.ba = 2'(b); o.done = d; o.req = r;
        return o;
    endfunction

    // Expected output after the e-th edge since reset release
    function automatic obs_t exp_at(input int t, input int stab, input int trp,
                                    input int tmrd, input int trfc, input int nref,
                                    input int trefi, input int mw, input int ew,
                                    output string tag);
        int p;
        tag = "R1";
        if (t <= stab) return mk(4'b0111, 0, 0, 1'b0, 1'b0);
        p = t - stab;
        tag = "R3 R2";
        if (p == 1) return mk(4'b0010, 1 << 10, 0, 1'b0, 1'b0);
        p -= 1;
        tag = "R4";
        if (p <= trp) return mk(4'b0111, 0, 0, 1'b0, 1'b0);
        p -= trp;
        if (p == 1) return mk(4'b0000, mw, 0, 1'b0, 1'b0);
        p -= 1;
        tag = "R5";
        if (p <= tmrd) return mk(4'b0111, 0, 0, 1'b0, 1'b0);
        p -= tmrd;
        if (p == 1) return mk(4'b0000, ew, 1, 1'b0, 1'b0);
        p -= 1;
        tag = "R6";
        if (p <= tmrd) return mk(4'b0111, 0, 0, 1'b0, 1'b0);
        p -= tmrd;
        for (int r = 0; r < nref; r++) begin
            if (p == 1) return mk(4'b0001, 0, 0, 1'b0, 1'b0);
            p -= 1;
            if (p <= trfc) return mk(4'b0111, 0, 0, 1'b0, 1'b0);
            p -= trfc;
        end
        tag = "R7 R8";
        p -= 1;
        return mk(4'b0111, 0, 0, 1'b1, (p > 0) && (p % trefi == 0));
    endfunction

    task automatic compare(input string inst, input string tag, input obs_t got, input obs_t exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s edge=%0d got=%h exp=%h", tag, inst, e, got, exp);
        end
    endtask

    task automatic step();
        obs_t ga, gb, ea, eb;
        string ta, tb;
        @(negedge clk);
        ga = mk({a_cs, a_ras, a_cas, a_we}, int'(a_addr), int'(a_ba), a_done, a_req);
        gb = mk({b_cs, b_ras, b_cas, b_we}, int'(b_addr), int'(b_ba), b_done, b_req);
        if (rst) begin
            // R9: reset state
            ea = mk(4'b0111, 0, 0, 1'b0, 1'b0);
            compare("A", "R9", ga, ea);
            compare("B", "R9", gb, ea);
        end else begin
            e++;
            ea = exp_at(e, A_STAB, A_RP, A_MRD, A_RFC, A_NREF, A_REFI, A_MW, A_EW, ta);
            eb = exp_at(e, B_STAB, B_RP, B_MRD, B_RFC, B_NREF, B_REFI, B_MW, B_EW, tb);
            compare("A", ta, ga, ea);
            compare("B", tb, gb, eb);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step();
        // full sequence for both configurations, R1..R8
        rst = 1'b0; e = 0;
        for (int i = 0; i < 5100; i++) step();
        // R9: reset after completion
        rst = 1'b1;
        for (int i = 0; i < 2; i++) step();
        // R9: reset during B's refresh phase and A's power-up wait
        rst = 1'b0; e = 0;
        for (int i = 0; i < 2010; i++) step();
        rst = 1'b1;
        for (int i = 0; i < 2; i++) step();
        // R9: restart runs the whole sequence again
        rst = 1'b0; e = 0;
        for (int i = 0; i < 5100; i++) step();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired edge=%0d got=running exp=finished", e);
        finish_run();
    end

endmodule